// File: doc/BRIEF.md
# Debounced level-triggered interrupt controller

This block watches a bank of external, input-only signals and turns them into one active-low interrupt request for a host processor. Every channel has its own input path. The raw pin first passes through a two-flop synchroniser. It then enters a filter that only accepts a new level once the pin has held that level for a programmable number of millisecond ticks. The millisecond tick comes from the system clock through a prescaler.

Detection is purely level based. Each channel carries a polarity bit that names its active level. A channel only latches a pending event after software arms it with a one-shot start write. A latched event stays pending until software clears it. Software can emulate edge detection by flipping the polarity after each event and re-arming the channel.

The host reaches the block through a simple single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `lvl_irq_debounce`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is 1.
- R2: The sampling-enable (0x04), polarity (0x08) and interrupt-enable (0x0C) registers read back bits NCH-1:0 as written, with upper bits 0. The length register of channel n sits at 0x40+4n and holds bits 11:0 only.
- R3: The level register (0x00, bit n per channel) changes to a new pin value only after the synchronised pin has differed from it for `len` consecutive ticks of TICK_DIV clocks. A shorter excursion resets the count. With `len` = 0 the level follows the synchronised pin one clock later.
- R4: While a channel's sampling-enable bit is 0, its level bit reads 0 and its raw status never sets.
- R5: Writing 1 to bit n of the arm register (0x1C) arms channel n. The raw status bit n (0x10) sets only while the channel is armed and its level equals its polarity bit. Setting the bit disarms the channel, so each arm yields at most one event.
- R6: Writing 1 to bit n of the clear register (0x18) clears raw status bit n. Zero bits have no effect. The clear and arm registers read as 0.
- R7: The pending register (0x14) equals raw status AND interrupt enable. `irq_n` is 0 exactly when any pending bit is 1.
- R8: Polarity bit 1 makes level 1 active. Polarity bit 0 makes level 0 active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NCH | Raw external inputs, one per channel |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| irq_n | output | 1 | Combined interrupt request, active low |

## Verification
The bench builds the block with the default 16 channels and with TICK_DIV set to 4, so one millisecond tick lasts four clocks. With that setting, debounce lengths of a few ticks finish within tens of cycles. The bench can then check that a level change is withheld before the window closes and accepted after it. It can also check that a short glitch restarts the count. The zero-length bypass, both polarities, sampling disable and the one-event-per-arm rule are all reached at these values.

// File: rtl/lvl_irq_debounce.sv
module lvl_irq_debounce #(
  parameter int NCH      = 16,
  parameter int TICK_DIV = 1000,
  parameter int LEN_W    = 12,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] pin_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_LEVEL = AW'(8'h00);
  localparam logic [AW-1:0] A_SAMP  = AW'(8'h04);
  localparam logic [AW-1:0] A_POL   = AW'(8'h08);
  localparam logic [AW-1:0] A_IEN   = AW'(8'h0C);
  localparam logic [AW-1:0] A_RAW   = AW'(8'h10);
  localparam logic [AW-1:0] A_PEND  = AW'(8'h14);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h18);
  localparam logic [AW-1:0] A_ARM   = AW'(8'h1C);
  localparam logic [AW-1:0] A_LEN0  = AW'(8'h40);

  logic [PW-1:0]    pcnt;
  logic             tick;
  logic [NCH-1:0]   s1, s2, lvl, armed, ris, hit;
  logic [NCH-1:0]   samp, pol, ien;
  logic [LEN_W-1:0] len [NCH];
  logic [LEN_W-1:0] cnt [NCH];
  logic [NCH-1:0]   arm_p, clr_p;
  logic [AW-1:0]    chofs;
  logic             ch_hit;
  logic [IW-1:0]    ch_idx;

  assign tick = (pcnt == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin s1 <= '0; s2 <= '0; end
    else        begin s1 <= pin_in; s2 <= s1; end

  assign chofs  = bus_addr - A_LEN0;
  assign ch_hit = (bus_addr >= A_LEN0) && (32'(chofs >> 2) < NCH) && (chofs[1:0] == 2'b00);
  assign ch_idx = chofs[IW+1:2];
  assign arm_p  = (bus_wr && bus_addr == A_ARM) ? bus_wdata[NCH-1:0] : '0;
  assign clr_p  = (bus_wr && bus_addr == A_CLR) ? bus_wdata[NCH-1:0] : '0;
  assign hit    = armed & samp & ~(lvl ^ pol);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      samp <= '0; pol <= '0; ien <= '0;
      for (int i = 0; i < NCH; i++) len[i] <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_SAMP) samp <= bus_wdata[NCH-1:0];
      if (bus_addr == A_POL)  pol  <= bus_wdata[NCH-1:0];
      if (bus_addr == A_IEN)  ien  <= bus_wdata[NCH-1:0];
      if (ch_hit)             len[ch_idx] <= bus_wdata[LEN_W-1:0];
    end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt[g] <= '0; lvl[g] <= 1'b0; armed[g] <= 1'b0; ris[g] <= 1'b0;
      end else begin
        if (!samp[g]) begin
          lvl[g] <= 1'b0; cnt[g] <= '0;
        end else if (s2[g] == lvl[g]) begin
          cnt[g] <= '0;
        end else if (len[g] == '0) begin
          lvl[g] <= s2[g]; cnt[g] <= '0;
        end else if (tick) begin
          if (({1'b0, cnt[g]} + 1'b1) >= {1'b0, len[g]}) begin
            lvl[g] <= s2[g]; cnt[g] <= '0;
          end else cnt[g] <= cnt[g] + 1'b1;
        end
        if (arm_p[g])    armed[g] <= 1'b1;
        else if (hit[g]) armed[g] <= 1'b0;
        if (hit[g])      ris[g] <= 1'b1;
        else if (clr_p[g]) ris[g] <= 1'b0;
      end

    AST_LVL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !samp[g] |=> !lvl[g]);  // R4
    AST_LVL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (samp[g] && $past(samp[g]) && lvl[g] != $past(lvl[g])) |-> lvl[g] == $past(s2[g]));  // R3
    AST_RAW_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ris[g]) |-> $past(armed[g]) && $past(lvl[g]) == $past(pol[g]));  // R5
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ris[g]) && !$past(arm_p[g])) |-> !armed[g]);  // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_p[g] && !hit[g]) |=> !ris[g]);  // R6
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LEVEL: bus_rdata[NCH-1:0] = lvl;
      A_SAMP:  bus_rdata[NCH-1:0] = samp;
      A_POL:   bus_rdata[NCH-1:0] = pol;
      A_IEN:   bus_rdata[NCH-1:0] = ien;
      A_RAW:   bus_rdata[NCH-1:0] = ris;
      A_PEND:  bus_rdata[NCH-1:0] = ris & ien;
      default: if (ch_hit) bus_rdata[LEN_W-1:0] = len[ch_idx];
    endcase
  end

  assign irq_n = ~|(ris & ien);

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0 || ris == '0) |-> irq_n);  // R7
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV > 1 && tick) |=> !tick);  // R3
endmodule

// File: tb/lvl_irq_debounce_tb.sv
module lvl_irq_debounce_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DIV = 4;

  logic        clk = 0, rst_n = 0, bus_wr = 0, irq_n;
  logic [15:0] pin_in = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_bad = 0;

  lvl_irq_debounce #(.NCH(NCH), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8'h80; a += 4) begin
      rd(8'(a), d); chk("R1 reset read", d, 0);
    end
    chk("R1 irq_n idle", {31'b0, irq_n}, 1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R2 samp width", d, 32'h0000_FFFF);
    wr(8'h08, 32'hA5A5_1234); rd(8'h08, d); chk("R2 pol", d, 32'h0000_1234);
    wr(8'h0C, 32'h0F0F_8001); rd(8'h0C, d); chk("R2 ien", d, 32'h0000_8001);
    wr(8'h54, 32'hFFFF_FFFF); rd(8'h54, d); chk("R2 len ch5", d, 32'h0000_0FFF);
    rd(8'h58, d); chk("R2 len ch6 untouched", d, 0);
    wr(8'h54, 0); wr(8'h04, 0); wr(8'h08, 0); wr(8'h0C, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'h04, 32'h0000_000B);
    wr(8'h44, 3);
    idle(2);
    pin_in[0] = 1; idle(4);
    rd(8'h00, d); chk("R3 zero length follows", d[0], 1);
    pin_in[1] = 1; idle(8);
    rd(8'h00, d); chk("R3 held before window", d[1], 0);
    idle(10);
    rd(8'h00, d); chk("R3 accepted after window", d[1], 1);
    pin_in[1] = 0; idle(6); pin_in[1] = 1; idle(20);
    rd(8'h00, d); chk("R3 glitch rejected", d[1], 1);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(8'h08, 32'h0000_0004);
    pin_in[2] = 1;
    wr(8'h1C, 32'h0000_0004); idle(6);
    rd(8'h00, d); chk("R4 level off", d[2], 0);
    rd(8'h10, d); chk("R4 raw off", d[2], 0);
    wr(8'h1C, 0);
  endtask

  task automatic t_arm;
    logic [31:0] d;
    wr(8'h08, 32'h0000_0001); wr(8'h0C, 32'h0000_0001); idle(3);
    rd(8'h10, d); chk("R5 no event unarmed", d[0], 0);
    chk("R7 irq idle unarmed", {31'b0, irq_n}, 1);
    wr(8'h1C, 32'h0000_0001); idle(1);
    rd(8'h10, d); chk("R5 raw set", d, 1);
    rd(8'h14, d); chk("R7 pend", d, 1);
    chk("R7 irq asserted", {31'b0, irq_n}, 0);
    rd(8'h1C, d); chk("R6 arm reads 0", d, 0);
    rd(8'h18, d); chk("R6 clear reads 0", d, 0);
    wr(8'h18, 32'h0000_0001); idle(4);
    rd(8'h10, d); chk("R5 one event per arm", d, 0);
    chk("R6 irq released", {31'b0, irq_n}, 1);
    wr(8'h1C, 32'h0000_0001); idle(1);
    wr(8'h18, 32'hFFFF_FFFE);
    rd(8'h10, d); chk("R6 zero bits ignored", d, 1);
    wr(8'h0C, 0);
    rd(8'h14, d); chk("R7 pend masked", d, 0);
    chk("R7 irq masked", {31'b0, irq_n}, 1);
    wr(8'h18, 32'h0000_0001);
  endtask

  task automatic t_low_pol;
    logic [31:0] d;
    wr(8'h04, 32'h0000_0009); wr(8'h08, 0); wr(8'h0C, 32'h0000_0008); idle(3);
    wr(8'h1C, 32'h0000_0008); idle(1);
    rd(8'h10, d); chk("R8 active low sets", d[3], 1);
    chk("R8 irq from low", {31'b0, irq_n}, 0);
    wr(8'h18, 32'h0000_0008);
    pin_in[3] = 1; idle(5);
    wr(8'h1C, 32'h0000_0008); idle(3);
    rd(8'h10, d); chk("R8 inactive high no set", d[3], 0);
    pin_in[3] = 0; idle(5);
    rd(8'h10, d); chk("R8 set on low level", d[3], 1);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(1);
        t_reset(); t_regs(); t_level(); t_disabled(); t_arm(); t_low_pol();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule